// File: doc/BRIEF.md
# SPI Register Access Front-End

This block is an SPI slave (clock idle low, data captured on the rising edge, most significant bit first). It turns a serial byte stream into parallel accesses for the rest of the chip. The first byte after chip select falls is a header. Its bit 7 is the read/write flag (1 = read), bit 6 is the burst flag, and bits 5:0 are an address. From the header the block classifies the access and carries it out on one of four parallel ports:

- register reads and writes, single or burst, on a register-file port;
- status-register reads, on the same port with a separate request line;
- command strobes, as a one-cycle request carrying the strobe address;
- byte pushes to a transmit FIFO and byte pops from a receive FIFO.

While every header is shifted in, the block returns a status byte on MISO. This byte shows the core state and a FIFO level. All SPI inputs are oversampled by the system clock, so the serial clock must be several times slower than `clk`.

Register and status read data are expected on `reg_rdata` one clock after the request. The receive FIFO is show-ahead: `rxf_data` always shows the head entry, and it advances one clock after `rxf_pop`.

Top module: `spi_regport`

## Requirements
- R1: A header byte is split as read/write = bit 7, burst = bit 6, address = bits 5:0. A single write header (bit 7 = 0, bit 6 = 0) to address 0x00-0x2F or 0x3E is followed by one data byte. That byte produces exactly one `reg_we` pulse carrying the header address and the data byte.
- R2: A single read header (bit 7 = 1, bit 6 = 0) to a register address raises `reg_re`. The returned `reg_rdata` is shifted out on MISO during the next byte.
- R3: In a burst register write, each data byte is written to the address of the previous one plus 1, for as long as chip select stays low.
- R4: In a burst register read, each successive byte on MISO returns the next higher register address.
- R5: A header to address 0x30-0x3D with bit 6 = 0 produces one `strobe_vld` pulse with that address and has no data byte. The next byte is decoded as a new header without chip select being raised.
- R6: A header to address 0x30-0x3D with bit 6 = 1 and bit 7 = 1 raises `sts_re` and returns one status-register byte. It is always a single access: the byte after it is decoded as a new header.
- R7: A header to address 0x30-0x3D with bit 6 = 1 and bit 7 = 0 is a write to a read-only location. Its data byte causes no register write and no strobe, and MISO returns 0x00 during that data byte.
- R8: Address 0x3F is the FIFO port. With bit 7 = 0, each data byte is pushed to the transmit FIFO (one byte, or every byte in burst). With bit 7 = 1, each byte returns the receive-FIFO head and pops it once it has been shifted out.
- R9: During every header byte, MISO carries {0, core_state[2:0], level[3:0]}. The level is `tx_space` when the header's bit 7 is 0 and `rx_level` when it is 1. During register, status-read and FIFO-write data bytes that return no read data, MISO carries the same byte with `tx_space`.
- R10: Raising chip select ends any access and discards a partial byte. The first byte after the next falling edge of chip select is a header. MISO is low while chip select is high.
- R11: After reset, MISO is low and no request output is asserted. At most one of `reg_we`, `reg_re`, `sts_re`, `strobe_vld`, `txf_push`, `rxf_pop` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock (idle low) |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| core_state | input | STATE_W | State field for the status byte |
| tx_space | input | FILL_W | Free space in the transmit FIFO |
| rx_level | input | FILL_W | Fill level of the receive FIFO |
| reg_addr | output | 6 | Register or status-register address |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | Register write pulse |
| reg_re | output | 1 | Register read request |
| sts_re | output | 1 | Status-register read request |
| reg_rdata | input | 8 | Read data, valid one clock after a request |
| strobe_vld | output | 1 | Command strobe pulse |
| strobe_addr | output | 6 | Address of the command strobe |
| txf_push | output | 1 | Transmit FIFO push pulse |
| txf_data | output | 8 | Byte pushed to the transmit FIFO |
| rxf_pop | output | 1 | Receive FIFO pop pulse |
| rxf_data | input | 8 | Receive FIFO head byte (show-ahead) |

## Verification
The assertions check the per-cycle rules on every clock:

- at most one request pulse is active at a time;
- the core sees no request once chip select has been high for a cycle;
- MISO is low after chip select goes high;
- strobe and status-read addresses stay inside the 0x30-0x3D window;
- each completed byte produces a one-cycle pulse.

Other behaviours depend on whole byte sequences, so only the bench scenarios can show them. These are the address steps in bursts, the re-entry into header decoding after strobes and status reads, the zero byte for read-only writes, the late choice of FIFO level in the status byte, and the recovery after an aborted byte.

// File: rtl/spi_regport_pkg.sv
`timescale 1ns/1ps
package spi_regport_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] WIN_LO    = 6'h30;
  localparam logic [ADDR_W-1:0] WIN_HI    = 6'h3D;
  localparam logic [ADDR_W-1:0] FIFO_PORT = 6'h3F;

  typedef struct packed {
    logic              rd;
    logic              burst;
    logic [ADDR_W-1:0] addr;
  } hdr_t;

  typedef enum logic [2:0] {
    ACC_REG, ACC_STROBE, ACC_STS, ACC_RO, ACC_TXF, ACC_RXF
  } acc_e;

  function automatic acc_e classify(input hdr_t h);
    if (h.addr == FIFO_PORT)
      return h.rd ? ACC_RXF : ACC_TXF;
    if (h.addr >= WIN_LO && h.addr <= WIN_HI) begin
      if (!h.burst) return ACC_STROBE;
      return h.rd ? ACC_STS : ACC_RO;
    end
    return ACC_REG;
  endfunction
endpackage

// File: rtl/spi_sync.sv
`timescale 1ns/1ps
module spi_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine
  import spi_regport_pkg::*;
#(
  parameter int FILL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              cs_act,
  input  logic              mosi_s,
  input  logic              ld,
  input  logic [BYTE_W-1:0] ld_byte,
  input  logic              ld_patch,
  input  logic [FILL_W-1:0] nib_tx,
  input  logic [FILL_W-1:0] nib_rx,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              miso
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic              sclk_q, patch_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic              rise, fall;

  assign rise = sclk_s & ~sclk_q;
  assign fall = ~sclk_s & sclk_q;
  assign miso = tx_sh[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0; patch_q <= 1'b0; bit_cnt <= '0;
      rx_sh <= '0; tx_sh <= '0; byte_vld <= 1'b0; rx_byte <= '0;
    end else begin
      sclk_q   <= sclk_s;
      byte_vld <= 1'b0;
      if (!cs_act) begin
        bit_cnt <= '0;
        tx_sh   <= '0;
        patch_q <= 1'b0;
      end else begin
        if (rise) begin
          rx_sh   <= {rx_sh[BYTE_W-3:0], mosi_s};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CNT_W'(BYTE_W-1)) begin
            byte_vld <= 1'b1;
            rx_byte  <= {rx_sh, mosi_s};
          end
          // level field chosen once the read/write bit of the header is seen
          if (bit_cnt == '0 && patch_q) begin
            tx_sh[FILL_W-1:0] <= mosi_s ? nib_rx : nib_tx;
            patch_q <= 1'b0;
          end
        end
        if (fall && bit_cnt != '0)
          tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        if (ld) begin
          tx_sh   <= ld_byte;
          patch_q <= ld_patch;
        end
      end
    end
  end

  // R10
  miso_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !miso);

  // R1
  byte_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    byte_vld |=> !byte_vld);
endmodule

// File: rtl/spi_access_ctrl.sv
`timescale 1ns/1ps
module spi_access_ctrl
  import spi_regport_pkg::*;
#(
  parameter int STATE_W = 3,
  parameter int FILL_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_act,
  input  logic               byte_vld,
  input  logic [BYTE_W-1:0]  rx_byte,
  input  logic [STATE_W-1:0] core_state,
  input  logic [FILL_W-1:0]  tx_space,
  input  logic [FILL_W-1:0]  rx_level,
  input  logic [BYTE_W-1:0]  reg_rdata,
  input  logic [BYTE_W-1:0]  rxf_data,
  output logic               ld,
  output logic [BYTE_W-1:0]  ld_byte,
  output logic               ld_patch,
  output logic [ADDR_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0]  reg_wdata,
  output logic               reg_we,
  output logic               reg_re,
  output logic               sts_re,
  output logic               strobe_vld,
  output logic [ADDR_W-1:0]  strobe_addr,
  output logic               txf_push,
  output logic [BYTE_W-1:0]  txf_data,
  output logic               rxf_pop
);
  localparam int PAD_W = BYTE_W - STATE_W - FILL_W;

  hdr_t              hdr;
  acc_e              cls, kind;
  logic              cs_q, in_data, rd_q, burst_q, pend_rx;
  logic [1:0]        pend_cnt;
  logic [ADDR_W-1:0] addr_q;

  assign hdr = hdr_t'(rx_byte);
  assign cls = classify(hdr);

  function automatic logic [BYTE_W-1:0] stat(input logic rd);
    return {{PAD_W{1'b0}}, core_state, rd ? rx_level : tx_space};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q <= 1'b0; in_data <= 1'b0; rd_q <= 1'b0; burst_q <= 1'b0;
      pend_rx <= 1'b0; pend_cnt <= '0; addr_q <= '0; kind <= ACC_REG;
      ld <= 1'b0; ld_byte <= '0; ld_patch <= 1'b0;
      reg_addr <= '0; reg_wdata <= '0; reg_we <= 1'b0; reg_re <= 1'b0;
      sts_re <= 1'b0; strobe_vld <= 1'b0; strobe_addr <= '0;
      txf_push <= 1'b0; txf_data <= '0; rxf_pop <= 1'b0;
    end else begin
      cs_q <= cs_act;
      ld <= 1'b0; reg_we <= 1'b0; reg_re <= 1'b0; sts_re <= 1'b0;
      strobe_vld <= 1'b0; txf_push <= 1'b0; rxf_pop <= 1'b0;
      if (!cs_act) begin
        in_data  <= 1'b0;
        pend_cnt <= '0;
      end else if (!cs_q) begin
        ld <= 1'b1; ld_byte <= stat(1'b0); ld_patch <= 1'b1;
      end else if (pend_cnt != '0) begin
        pend_cnt <= pend_cnt - 1'b1;
        if (pend_cnt == 2'd1) begin
          ld <= 1'b1; ld_patch <= 1'b0;
          ld_byte <= pend_rx ? rxf_data : reg_rdata;
        end
      end else if (byte_vld && !in_data) begin
        rd_q <= hdr.rd; burst_q <= hdr.burst; addr_q <= hdr.addr; kind <= cls;
        ld <= 1'b1; ld_patch <= 1'b0; ld_byte <= stat(1'b0);
        in_data <= 1'b1;
        case (cls)
          ACC_STROBE: begin
            strobe_vld <= 1'b1; strobe_addr <= hdr.addr;
            in_data <= 1'b0; ld_patch <= 1'b1;
          end
          ACC_STS: begin
            ld <= 1'b0; sts_re <= 1'b1; reg_addr <= hdr.addr;
            pend_cnt <= 2'd2; pend_rx <= 1'b0;
          end
          ACC_RO:  ld_byte <= '0;
          ACC_RXF: ld_byte <= rxf_data;
          ACC_TXF: ;
          default: if (hdr.rd) begin
            ld <= 1'b0; reg_re <= 1'b1; reg_addr <= hdr.addr;
            pend_cnt <= 2'd2; pend_rx <= 1'b0;
          end
        endcase
      end else if (byte_vld) begin
        // defaults: return to header decoding with a fresh status byte
        ld <= 1'b1; ld_byte <= stat(1'b0); ld_patch <= 1'b1; in_data <= 1'b0;
        case (kind)
          ACC_REG: begin
            if (!rd_q) begin
              reg_we <= 1'b1; reg_addr <= addr_q; reg_wdata <= rx_byte;
            end
            if (burst_q) begin
              in_data <= 1'b1; ld_patch <= 1'b0;
              addr_q  <= addr_q + 1'b1;
              if (rd_q) begin
                ld <= 1'b0; reg_re <= 1'b1; reg_addr <= addr_q + 1'b1;
                pend_cnt <= 2'd2; pend_rx <= 1'b0;
              end
            end
          end
          ACC_TXF: begin
            txf_push <= 1'b1; txf_data <= rx_byte;
            if (burst_q) begin in_data <= 1'b1; ld_patch <= 1'b0; end
          end
          ACC_RXF: begin
            rxf_pop <= 1'b1;
            if (burst_q) begin
              in_data <= 1'b1; ld <= 1'b0; pend_cnt <= 2'd2; pend_rx <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11
  one_req_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reg_we, reg_re, sts_re, strobe_vld, txf_push, rxf_pop}));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_act && $past(!cs_act)) |->
      !(reg_we | reg_re | sts_re | strobe_vld | txf_push | rxf_pop));

  // R5
  strobe_win_chk: assert property (@(posedge clk) disable iff (rst)
    strobe_vld |-> (strobe_addr >= WIN_LO && strobe_addr <= WIN_HI));

  // R6
  sts_win_chk: assert property (@(posedge clk) disable iff (rst)
    sts_re |-> (reg_addr >= WIN_LO && reg_addr <= WIN_HI));
endmodule

// File: rtl/spi_regport.sv
`timescale 1ns/1ps
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STATE_W     = 3,
  parameter int FILL_W      = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               spi_sclk,
  input  logic               spi_csn,
  input  logic               spi_mosi,
  output logic               spi_miso,
  input  logic [STATE_W-1:0] core_state,
  input  logic [FILL_W-1:0]  tx_space,
  input  logic [FILL_W-1:0]  rx_level,
  output logic [ADDR_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0]  reg_wdata,
  output logic               reg_we,
  output logic               reg_re,
  output logic               sts_re,
  input  logic [BYTE_W-1:0]  reg_rdata,
  output logic               strobe_vld,
  output logic [ADDR_W-1:0]  strobe_addr,
  output logic               txf_push,
  output logic [BYTE_W-1:0]  txf_data,
  output logic               rxf_pop,
  input  logic [BYTE_W-1:0]  rxf_data
);
  logic [2:0]        pins_s;
  logic              byte_vld, ld, ld_patch;
  logic [BYTE_W-1:0] rx_byte, ld_byte;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_sclk, spi_csn, spi_mosi}), .q(pins_s)
  );

  spi_shift_engine #(.FILL_W(FILL_W)) u_eng (
    .clk(clk), .rst(rst),
    .sclk_s(pins_s[2]), .cs_act(~pins_s[1]), .mosi_s(pins_s[0]),
    .ld(ld), .ld_byte(ld_byte), .ld_patch(ld_patch),
    .nib_tx(tx_space), .nib_rx(rx_level),
    .byte_vld(byte_vld), .rx_byte(rx_byte), .miso(spi_miso)
  );

  spi_access_ctrl #(.STATE_W(STATE_W), .FILL_W(FILL_W)) u_ctrl (
    .clk(clk), .rst(rst), .cs_act(~pins_s[1]),
    .byte_vld(byte_vld), .rx_byte(rx_byte),
    .core_state(core_state), .tx_space(tx_space), .rx_level(rx_level),
    .reg_rdata(reg_rdata), .rxf_data(rxf_data),
    .ld(ld), .ld_byte(ld_byte), .ld_patch(ld_patch),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .sts_re(sts_re),
    .strobe_vld(strobe_vld), .strobe_addr(strobe_addr),
    .txf_push(txf_push), .txf_data(txf_data), .rxf_pop(rxf_pop)
  );
endmodule

// File: tb/tb_spi_regport.sv
`timescale 1ns/1ps
module tb_spi_regport;
  localparam int HALF = 8;
  localparam logic [7:0] ST_W = 8'h5A; // {0,101,tx_space=A}
  localparam logic [7:0] ST_R = 8'h53; // {0,101,rx_level=3}
  localparam logic [13:0] VEC [0:5] = '{
    {6'h00, 8'h11}, {6'h05, 8'hA7}, {6'h2F, 8'h3C},
    {6'h3E, 8'hF0}, {6'h10, 8'h00}, {6'h1A, 8'hFF}};

  logic clk = 0, rst = 1;
  logic spi_sclk = 0, spi_csn = 1, spi_mosi = 0, spi_miso;
  logic [5:0] reg_addr, strobe_addr;
  logic [7:0] reg_wdata, reg_rdata, txf_data, rxf_data, rx_rd;
  logic reg_we, reg_re, sts_re, strobe_vld, txf_push, rxf_pop;
  logic [7:0] regmem [0:63];

  int errors = 0, checks = 0;
  int we_n = 0, sts_n = 0, strobe_n = 0, push_n = 0, pop_n = 0;
  logic [5:0] last_we_addr, strobe_log [0:7];
  logic [7:0] last_we_data, push_log [0:7];
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_regport dut (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .core_state(3'b101),
    .tx_space(4'hA), .rx_level(4'h3), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re), .sts_re(sts_re),
    .reg_rdata(reg_rdata), .strobe_vld(strobe_vld), .strobe_addr(strobe_addr),
    .txf_push(txf_push), .txf_data(txf_data), .rxf_pop(rxf_pop),
    .rxf_data(rxf_data));

  assign rxf_data = 8'h90 + rx_rd;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) regmem[i] <= 8'(i) ^ 8'h5A;
      rx_rd <= 0; reg_rdata <= 0;
    end else begin
      if (reg_we) regmem[reg_addr] <= reg_wdata;
      if (reg_re) reg_rdata <= regmem[reg_addr];
      else if (sts_re) reg_rdata <= 8'hC0 | {2'b00, reg_addr};
      if (rxf_pop) rx_rd <= rx_rd + 1;
    end
  end

  always @(posedge clk) if (!rst) begin
    if (reg_we) begin we_n++; last_we_addr = reg_addr; last_we_data = reg_wdata; end
    if (sts_re) sts_n++;
    if (strobe_vld) begin strobe_log[strobe_n % 8] = strobe_addr; strobe_n++; end
    if (txf_push) begin push_log[push_n % 8] = txf_data; push_n++; end
    if (rxf_pop) pop_n++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cs_lo;
    @(negedge clk) spi_csn = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic cs_hi;
    repeat (4) @(negedge clk);
    spi_csn = 1;
    repeat (12) @(negedge clk);
  endtask

  task automatic xbits(input logic [7:0] b, input int n, output logic [7:0] r);
    r = 0;
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk) spi_mosi = b[i];
      repeat (HALF) @(negedge clk);
      spi_sclk = 1; r[i] = spi_miso;
      repeat (HALF) @(negedge clk);
      spi_sclk = 0;
    end
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    xbits(b, 8, r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int n0;
    repeat (6) @(negedge clk);
    rst = 0;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(spi_miso == 0 && !reg_we && !reg_re && !sts_re && !strobe_vld && !txf_push && !rxf_pop,
        "R11 reset outputs", spi_miso, 0);
    chk(we_n + strobe_n + push_n + pop_n + sts_n == 0, "R11 no requests", we_n, 0);

    // vector table: single write then single read back (R1, R2, R9)
    for (int k = 0; k < 6; k++) begin
      logic [5:0] a; logic [7:0] d;
      a = VEC[k][13:8]; d = VEC[k][7:0];
      cs_lo; xfer({2'b00, a}, r);
      chk(r == ST_W, "R9 status on write header", r, ST_W);
      xfer(d, r); cs_hi;
      chk(last_we_addr == a && last_we_data == d, "R1 write addr/data",
          {last_we_addr, last_we_data}, {a, d});
      cs_lo; xfer({2'b10, a}, r);
      chk(r == ST_R, "R9 status on read header", r, ST_R);
      xfer(8'h00, r); cs_hi;
      chk(r == d, "R2 single read data", r, d);
    end
    chk(we_n == 6, "R1 one write per access", we_n, 6);

    // R3 burst write, R4 burst read
    n0 = we_n;
    cs_lo; xfer(8'h48, r);
    for (int i = 0; i < 3; i++) xfer(8'h21 + 8'(i), r);
    cs_hi;
    chk(we_n == n0 + 3 && last_we_addr == 6'h0A, "R3 burst write count/addr", last_we_addr, 6'h0A);
    cs_lo; xfer(8'hC8, r);
    for (int i = 0; i < 3; i++) begin
      xfer(8'h00, r);
      chk(r == 8'h21 + 8'(i), "R4 burst read data", r, 8'h21 + i);
    end
    cs_hi;

    // R5 strobes followed by headers without raising chip select
    cs_lo; xfer(8'h36, r);
    chk(r == ST_W, "R5 status during strobe", r, ST_W);
    xfer(8'hB1, r);
    chk(r == ST_R, "R5 strobe header rw=1 status", r, ST_R);
    xfer(8'h85, r); xfer(8'h00, r);
    chk(r == 8'hA7, "R5 header after strobes", r, 8'hA7);
    cs_hi;
    chk(strobe_n == 2 && strobe_log[0] == 6'h36 && strobe_log[1] == 6'h31,
        "R5 strobe pulses", strobe_n, 2);

    // R6 status read is single
    cs_lo; xfer(8'hF5, r); xfer(8'h00, r);
    chk(r == 8'hF5, "R6 status register data", r, 8'hF5);
    xfer(8'h80, r);
    chk(r == ST_R, "R6 next byte is header", r, ST_R);
    xfer(8'h00, r);
    chk(r == 8'h11, "R6 register read after status", r, 8'h11);
    cs_hi;
    chk(sts_n == 1, "R6 one status request", sts_n, 1);

    // R7 write to read-only window
    n0 = we_n;
    cs_lo; xfer(8'h72, r); xfer(8'h77, r); cs_hi;
    chk(r == 8'h00, "R7 zero data on SO", r, 0);
    chk(we_n == n0 && strobe_n == 2, "R7 no write/strobe", we_n, n0);

    // R8 TX FIFO single and burst
    cs_lo; xfer(8'h3F, r); xfer(8'hD1, r); cs_hi;
    cs_lo; xfer(8'h7F, r);
    for (int i = 0; i < 3; i++) xfer(8'hE0 + 8'(i), r);
    cs_hi;
    chk(push_n == 4 && push_log[0] == 8'hD1 && push_log[3] == 8'hE2,
        "R8 tx pushes", push_n, 4);

    // R8 RX FIFO single and burst
    cs_lo; xfer(8'hBF, r); xfer(8'h00, r); cs_hi;
    chk(r == 8'h90, "R8 rx single", r, 8'h90);
    cs_lo; xfer(8'hFF, r);
    for (int i = 0; i < 3; i++) begin
      xfer(8'h00, r);
      chk(r == 8'h91 + 8'(i), "R8 rx burst", r, 8'h91 + i);
    end
    cs_hi;
    chk(pop_n == 4, "R8 pops match bytes", pop_n, 4);

    // R10 abort mid-byte
    n0 = we_n;
    cs_lo; xfer(8'h4C, r); xbits(8'hFF, 4, r); cs_hi;
    chk(spi_miso == 0, "R10 MISO low when deselected", spi_miso, 0);
    chk(we_n == n0, "R10 partial byte discarded", we_n, n0);
    cs_lo; xfer(8'h8C, r);
    chk(r == ST_R, "R10 header after reselect", r, ST_R);
    xfer(8'h00, r); cs_hi;
    chk(r == 8'h56, "R10 register untouched", r, 8'h56);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule